// File: doc/BRIEF.md
# Key-Guarded Independent Watchdog

This block is a watchdog timer that a system places beside its processors to force a reset when software stops servicing it. It counts down on a low-speed time base, given here as a one-cycle tick enable `lsi_tick` in the bus clock domain. A programmable prescaler divides the tick stream, and a 12-bit reload value sets how many divided periods pass before expiry. When the counter runs out, the block pulses a reset request, reloads itself and keeps counting. Once started, it cannot be stopped.

Software reaches the block through a simple register port with a write strobe and a combinational read. Every command goes through a key register. One magic value opens the prescaler and reload registers for writing. A second value refreshes the counter. A third value starts the timer. Any other key value closes the registers again. Configuration writes do not take effect in the counting logic at once. Each one raises a status flag, and the new value is committed only after a fixed number of low-speed ticks, which models the delay of crossing into the slow domain.

An early-warning compare can raise a sticky interrupt before expiry, so software gets a last chance to refresh the timer. Writing a one to a clear bit in the same register removes the interrupt.

Top module: `kwdt_top`

## Requirements
- R1: After reset the timer is stopped and the registers are locked. Prescaler reads 0, reload reads 0xFFF, status reads 0 and early-warning control reads 0. `wdg_reset_req` and `ew_irq` are low.
- R2: Byte offsets on `bus_addr`: key 0x00 (reads 0), prescaler 0x04 (bits 3:0), reload 0x08 (bits 11:0), status 0x0C and early-warning control 0x14. Any other offset reads 0.
- R3: Writing 0x5555 in bits 15:0 of the key register unlocks the prescaler and reload registers. Any other key value locks them again. While they are locked, writes to them change nothing and raise no status flag.
- R4: Key 0xCCCC starts the timer. It loads the counter from the committed reload value and clears the prescaler phase. The timer never expires while stopped, and once running no write can stop it.
- R5: Key 0xAAAA loads the counter from the committed reload value and clears the prescaler phase.
- R6: A committed prescaler code c gives one counter decrement every 4·2^min(c,6) ticks. Code 6 and every code above it divide by 256.
- R7: Starting from a start or a refresh with committed reload value N and division D, `wdg_reset_req` goes high for one clock after exactly (N+1)·D ticks. The counter then reloads and the same period repeats.
- R8: Status bit 0 is the prescaler update, bit 1 the reload update and bit 3 the early-warning update. Bit 2 reads 0. A flag is set by an accepted write and clears after exactly SYNC_TICKS ticks, the moment the value is committed. A further write while the flag is set restarts that wait.
- R9: Early-warning control bit 15 is the enable and bits 11:0 are the compare value. This register is never locked. With the enable committed, a decrement that lands the counter on the compare value sets `ew_irq`. Loading the counter never sets it. The interrupt stays high until cleared.
- R10: A write with bit 14 set clears `ew_irq` on the next clock. Bit 14 is not stored and reads 0.
- R11: Refreshing the timer before (N+1)·D ticks have passed prevents the reset request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| lsi_tick | input | 1 | One-cycle enable per low-speed clock period |
| bus_addr | input | 5 | Register byte offset |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| wdg_reset_req | output | 1 | One-cycle reset request on expiry |
| ew_irq | output | 1 | Sticky early-warning interrupt |

## Verification
Each register write takes effect at the clock edge that samples it. Readback and status-set checks are therefore taken at the falling edge right after the write. The reset request and the early-warning interrupt are due a computed number of ticks after the refresh that started the count: (N+1)·D for expiry and (N−C)·D for the early warning. The bench counts only the ticks it drives and samples after each one, and it drives no tick during bus writes, so each count starts exactly at the refresh. Status flags are sampled after every tick of the SYNC_TICKS window. One run spaces the ticks apart to show that only ticks are counted, not bus clocks.

// File: rtl/kwdt_pkg.sv
package kwdt_pkg;

    localparam int unsigned ADDR_W = 5;
    localparam int unsigned CNT_W  = 12;

    localparam logic [ADDR_W-1:0] OFF_KEY = 5'h00;
    localparam logic [ADDR_W-1:0] OFF_PRE = 5'h04;
    localparam logic [ADDR_W-1:0] OFF_RLD = 5'h08;
    localparam logic [ADDR_W-1:0] OFF_STS = 5'h0C;
    localparam logic [ADDR_W-1:0] OFF_EWC = 5'h14;

    localparam logic [15:0] KEY_OPEN    = 16'h5555;
    localparam logic [15:0] KEY_REFRESH = 16'hAAAA;
    localparam logic [15:0] KEY_GO      = 16'hCCCC;

    localparam int unsigned EW_EN_BIT  = 15;
    localparam int unsigned EW_CLR_BIT = 14;

    typedef enum logic [2:0] {
        KC_IDLE,
        KC_OPEN,
        KC_REFRESH,
        KC_GO,
        KC_OTHER
    } key_cmd_t;

    typedef struct packed {
        logic             en;
        logic [CNT_W-1:0] cmp;
    } ew_cfg_t;

    function automatic logic [3:0] clamp_code(input logic [3:0] code,
                                              input int unsigned maxc);
        if (int'(code) > int'(maxc)) return 4'(maxc);
        return code;
    endfunction

endpackage

// File: rtl/kwdt_keydec.sv
module kwdt_keydec
    import kwdt_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        key_wr,
    input  logic [15:0] key_val,
    output key_cmd_t    cmd,
    output logic        unlocked
);

    always_comb begin
        cmd = KC_IDLE;
        if (key_wr) begin
            case (key_val)
                KEY_OPEN:    cmd = KC_OPEN;
                KEY_REFRESH: cmd = KC_REFRESH;
                KEY_GO:      cmd = KC_GO;
                default:     cmd = KC_OTHER;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            unlocked <= 1'b0;
        end else if (key_wr) begin
            unlocked <= (cmd == KC_OPEN);
        end
    end

endmodule

// File: rtl/kwdt_sync_slot.sv
module kwdt_sync_slot #(
    parameter int unsigned W          = 4,
    parameter int unsigned SYNC_TICKS = 3,
    parameter logic [W-1:0] RST_VAL   = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] shadow,
    output logic [W-1:0] active,
    output logic         pending
);

    always_ff @(posedge clk) begin
        if (rst) begin
            shadow <= RST_VAL;
        end else if (wr) begin
            shadow <= wdata;
        end
    end

    generate
        if (SYNC_TICKS == 0) begin : g_direct
            assign active  = shadow;
            assign pending = 1'b0;
        end else begin : g_delayed
            localparam int unsigned CW = (SYNC_TICKS > 1) ? $clog2(SYNC_TICKS) : 1;
            localparam logic [CW-1:0] LAST = CW'(SYNC_TICKS - 1);

            logic [CW-1:0] wait_cnt;
            logic [W-1:0]  committed;
            logic          busy;

            always_ff @(posedge clk) begin
                if (rst) begin
                    wait_cnt  <= '0;
                    committed <= RST_VAL;
                    busy      <= 1'b0;
                end else if (wr) begin
                    wait_cnt <= '0;
                    busy     <= 1'b1;
                end else if (busy && tick) begin
                    if (wait_cnt == LAST) begin
                        committed <= shadow;
                        busy      <= 1'b0;
                    end else begin
                        wait_cnt <= wait_cnt + 1'b1;
                    end
                end
            end

            assign active  = committed;
            assign pending = busy;
        end
    endgenerate

endmodule

// File: rtl/kwdt_prescaler.sv
module kwdt_prescaler
    import kwdt_pkg::*;
#(
    parameter int unsigned MAX_CODE = 6
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       run,
    input  logic       restart,
    input  logic [3:0] code,
    output logic       step
);

    localparam int unsigned PCNT_W = MAX_CODE + 2;

    logic [PCNT_W:0]   span;
    logic [PCNT_W-1:0] last;
    logic [PCNT_W-1:0] phase;

    always_comb begin
        span = (PCNT_W + 1)'(4) << clamp_code(code, MAX_CODE);
        last = PCNT_W'(span - 1'b1);
    end

    assign step = run && tick && !restart && (phase == last);

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            phase <= '0;
        end else if (run && tick) begin
            phase <= step ? '0 : phase + 1'b1;
        end
    end

endmodule

// File: rtl/kwdt_downcnt.sv
module kwdt_downcnt
    import kwdt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             go,
    input  logic             refresh,
    input  logic             step,
    input  logic [CNT_W-1:0] reload_val,
    input  ew_cfg_t          ew_cfg,
    input  logic             ew_clr,
    output logic             running,
    output logic             expire,
    output logic             ew_flag
);

    logic [CNT_W-1:0] cnt;
    logic             load;
    logic             lands_on_cmp;

    assign load         = go || refresh;
    assign lands_on_cmp = step && !load && (cnt != '0) &&
                          ((cnt - 1'b1) == ew_cfg.cmp) && ew_cfg.en;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt     <= '1;
            running <= 1'b0;
            expire  <= 1'b0;
        end else begin
            expire <= 1'b0;
            if (go) begin
                running <= 1'b1;
            end
            if (load) begin
                cnt <= reload_val;
            end else if (step) begin
                if (cnt == '0) begin
                    expire <= 1'b1;
                    cnt    <= reload_val;
                end else begin
                    cnt <= cnt - 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ew_flag <= 1'b0;
        end else if (lands_on_cmp) begin
            ew_flag <= 1'b1;
        end else if (ew_clr) begin
            ew_flag <= 1'b0;
        end
    end

endmodule

// File: rtl/kwdt_top.sv
module kwdt_top
    import kwdt_pkg::*;
#(
    parameter int unsigned SYNC_TICKS = 3,
    parameter int unsigned MAX_CODE   = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              lsi_tick,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              wdg_reset_req,
    output logic              ew_irq
);

    localparam int unsigned EW_W = $bits(ew_cfg_t);

    key_cmd_t         cmd;
    logic             unlocked;
    logic             wr_key, wr_pre, wr_rld, wr_ewc;
    logic [3:0]       pre_shadow, pre_active;
    logic [CNT_W-1:0] rld_shadow, rld_active;
    ew_cfg_t          ew_wdata, ew_shadow, ew_active;
    logic             pre_pend, rld_pend, ew_pend;
    logic             running, step, ew_clr;
    logic             unused_wbits;

    assign wr_key = bus_wr && (bus_addr == OFF_KEY);
    assign wr_pre = bus_wr && (bus_addr == OFF_PRE) && unlocked;
    assign wr_rld = bus_wr && (bus_addr == OFF_RLD) && unlocked;
    assign wr_ewc = bus_wr && (bus_addr == OFF_EWC);
    assign ew_clr = wr_ewc && bus_wdata[EW_CLR_BIT];

    assign ew_wdata.en  = bus_wdata[EW_EN_BIT];
    assign ew_wdata.cmp = bus_wdata[CNT_W-1:0];

    assign unused_wbits = ^{bus_wdata[31:16], bus_wdata[13:12]};

    kwdt_keydec keydec_i (
        .clk      (clk),
        .rst      (rst),
        .key_wr   (wr_key),
        .key_val  (bus_wdata[15:0]),
        .cmd      (cmd),
        .unlocked (unlocked)
    );

    kwdt_sync_slot #(.W(4), .SYNC_TICKS(SYNC_TICKS), .RST_VAL(4'h0)) pre_slot_i (
        .clk     (clk),
        .rst     (rst),
        .tick    (lsi_tick),
        .wr      (wr_pre),
        .wdata   (bus_wdata[3:0]),
        .shadow  (pre_shadow),
        .active  (pre_active),
        .pending (pre_pend)
    );

    kwdt_sync_slot #(.W(CNT_W), .SYNC_TICKS(SYNC_TICKS), .RST_VAL({CNT_W{1'b1}})) rld_slot_i (
        .clk     (clk),
        .rst     (rst),
        .tick    (lsi_tick),
        .wr      (wr_rld),
        .wdata   (bus_wdata[CNT_W-1:0]),
        .shadow  (rld_shadow),
        .active  (rld_active),
        .pending (rld_pend)
    );

    kwdt_sync_slot #(.W(EW_W), .SYNC_TICKS(SYNC_TICKS), .RST_VAL('0)) ew_slot_i (
        .clk     (clk),
        .rst     (rst),
        .tick    (lsi_tick),
        .wr      (wr_ewc),
        .wdata   (ew_wdata),
        .shadow  (ew_shadow),
        .active  (ew_active),
        .pending (ew_pend)
    );

    kwdt_prescaler #(.MAX_CODE(MAX_CODE)) presc_i (
        .clk     (clk),
        .rst     (rst),
        .tick    (lsi_tick),
        .run     (running),
        .restart (cmd == KC_GO || cmd == KC_REFRESH),
        .code    (pre_active),
        .step    (step)
    );

    kwdt_downcnt cnt_i (
        .clk        (clk),
        .rst        (rst),
        .go         (cmd == KC_GO),
        .refresh    (cmd == KC_REFRESH),
        .step       (step),
        .reload_val (rld_active),
        .ew_cfg     (ew_active),
        .ew_clr     (ew_clr),
        .running    (running),
        .expire     (wdg_reset_req),
        .ew_flag    (ew_irq)
    );

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            OFF_PRE: bus_rdata[3:0]       = pre_shadow;
            OFF_RLD: bus_rdata[CNT_W-1:0] = rld_shadow;
            OFF_STS: bus_rdata[3:0]       = {ew_pend, 1'b0, rld_pend, pre_pend};
            OFF_EWC: begin
                bus_rdata[EW_EN_BIT]   = ew_shadow.en;
                bus_rdata[CNT_W-1:0]   = ew_shadow.cmp;
            end
            default: bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/kwdt_chk.sv
module kwdt_chk
    import kwdt_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [15:0]       wlow,
    input logic              unlocked,
    input logic [3:0]        pre_shadow,
    input logic              pre_pend,
    input logic              running,
    input logic              wdg_reset_req,
    input logic              ew_irq
);

    AST_RST_PULSE: assert property (@(posedge clk) disable iff (rst)
        wdg_reset_req |=> !wdg_reset_req);                              // R7

    AST_RESET_NEEDS_RUN: assert property (@(posedge clk) disable iff (rst)
        wdg_reset_req |-> running);                                     // R4

    AST_NO_STOP: assert property (@(posedge clk) disable iff (rst)
        running |=> running);                                           // R4

    AST_LOCKED_IGNORE: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == OFF_PRE && !unlocked) |=> $stable(pre_shadow)); // R3

    AST_UNLOCK_KEY: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == OFF_KEY) |=> (unlocked == ($past(wlow) == KEY_OPEN))); // R3

    AST_PEND_ON_WRITE: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == OFF_PRE && unlocked) |=> pre_pend);      // R8

    AST_IRQ_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == OFF_EWC && wlow[EW_CLR_BIT] && !running) |=> !ew_irq); // R10

endmodule

bind kwdt_top kwdt_chk chk_i (
    .clk           (clk),
    .rst           (rst),
    .bus_wr        (bus_wr),
    .bus_addr      (bus_addr),
    .wlow          (bus_wdata[15:0]),
    .unlocked      (unlocked),
    .pre_shadow    (pre_shadow),
    .pre_pend      (pre_pend),
    .running       (running),
    .wdg_reset_req (wdg_reset_req),
    .ew_irq        (ew_irq)
);

// File: tb/kwdt_top_tb_top.sv
`timescale 1ns/1ps
module kwdt_top_tb_top;

    localparam int S = 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        lsi_tick = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        wdg_reset_req;
    logic        ew_irq;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    kwdt_top #(.SYNC_TICKS(S), .MAX_CODE(6)) dut_i (
        .clk           (clk),
        .rst           (rst),
        .lsi_tick      (lsi_tick),
        .bus_addr      (bus_addr),
        .bus_wr        (bus_wr),
        .bus_wdata     (bus_wdata),
        .bus_rdata     (bus_rdata),
        .wdg_reset_req (wdg_reset_req),
        .ew_irq        (ew_irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        lsi_tick  = 1'b0;
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            lsi_tick = 1'b1;
            @(negedge clk);
            lsi_tick = 1'b0;
        end
    endtask

    // Counts driven ticks until the chosen output is seen; -1 if maxn ticks pass.
    task automatic count_until(input bit use_irq, input int maxn, input int gap, output int n);
        n = 0;
        while (1) begin
            if (n >= maxn) begin
                n = -1;
                break;
            end
            lsi_tick = 1'b1;
            @(negedge clk);
            lsi_tick = 1'b0;
            n++;
            if (use_irq ? ew_irq : wdg_reset_req) break;
            repeat (gap) @(negedge clk);
        end
    endtask

    task automatic cfg(input logic [3:0] p, input logic [11:0] r);
        wr(5'h00, 32'h5555);
        wr(5'h04, {28'h0, p});
        wr(5'h08, {20'h0, r});
        ticks(S);
        wr(5'h00, 32'hAAAA);
    endtask

    function automatic int divof(input int p);
        return 4 << ((p > 6) ? 6 : p);
    endfunction

    initial begin
        logic [31:0] v;
        int n;

        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(5'h04, v); check("R1 presc", v, 32'h0);
        rd(5'h08, v); check("R1 reload", v, 32'hFFF);
        rd(5'h0C, v); check("R1 status", v, 32'h0);
        rd(5'h14, v); check("R1 ewctrl", v, 32'h0);
        check("R1 outputs", {30'h0, wdg_reset_req, ew_irq}, 32'h0);
        // R2 key reads zero, unmapped offset reads zero
        rd(5'h00, v); check("R2 key read", v, 32'h0);
        rd(5'h10, v); check("R2 unmapped", v, 32'h0);

        // R3 locked write ignored
        wr(5'h04, 32'h5);
        rd(5'h04, v); check("R3 locked presc", v, 32'h0);
        rd(5'h0C, v); check("R3 no flag", v, 32'h0);
        wr(5'h00, 32'h5555);
        wr(5'h04, 32'h1);
        rd(5'h04, v); check("R3 unlocked presc", v, 32'h1);
        wr(5'h00, 32'h1234);
        wr(5'h08, 32'h5);
        rd(5'h08, v); check("R3 relocked reload", v, 32'hFFF);
        ticks(S);

        // R8 flag timing
        wr(5'h00, 32'h5555);
        wr(5'h04, 32'h2);
        rd(5'h0C, v); check("R8 flag set", v, 32'h1);
        for (int j = 1; j <= S; j++) begin
            ticks(1);
            rd(5'h0C, v); check("R8 flag window", v, (j < S) ? 32'h1 : 32'h0);
        end
        wr(5'h08, 32'h3);
        ticks(1);
        wr(5'h08, 32'h3);
        ticks(S - 1);
        rd(5'h0C, v); check("R8 restart pending", v, 32'h2);
        ticks(1);
        rd(5'h0C, v); check("R8 restart cleared", v, 32'h0);

        // R4 no expiry while stopped (presc 2, reload 3)
        count_until(0, 80, 0, n); check("R4 stopped", n, -1);
        wr(5'h00, 32'hCCCC);
        count_until(0, 200, 0, n); check("R4 R7 start timeout", n, 4 * 16);

        // R6 R7 sweep
        for (int p = 0; p < 4; p++) begin
            for (int k = 0; k < 3; k++) begin
                int r;
                r = (k == 0) ? 0 : (k == 1) ? 3 : 7;
                cfg(p[3:0], r[11:0]);
                count_until(0, 600, 0, n);
                check($sformatf("R6 R7 p=%0d r=%0d", p, r), n, (r + 1) * divof(p));
            end
        end
        count_until(0, 600, 0, n); check("R7 repeat period", n, 8 * divof(3));

        // R6 saturation
        cfg(4'd6, 12'd0);
        count_until(0, 600, 0, n); check("R6 code6", n, 256);
        cfg(4'd9, 12'd1);
        count_until(0, 600, 0, n); check("R6 code9", n, 512);

        // R11 refresh holds off, R5 refresh reloads
        cfg(4'd0, 12'd3);
        for (int i = 0; i < 8; i++) begin
            wr(5'h00, 32'hAAAA);
            count_until(0, 12, 0, n); check("R11 held off", n, -1);
        end
        wr(5'h00, 32'hAAAA);
        count_until(0, 40, 0, n); check("R5 refresh reload", n, 16);

        // R4 cannot stop
        wr(5'h00, 32'hAAAA);
        wr(5'h00, 32'h0000);
        wr(5'h00, 32'h1234);
        wr(5'h00, 32'h5555);
        count_until(0, 40, 0, n); check("R4 unstoppable", n, 16);

        // R7 ticks spaced out
        wr(5'h00, 32'hAAAA);
        count_until(0, 40, 3, n); check("R7 sparse ticks", n, 16);

        // R9 early warning
        cfg(4'd0, 12'd7);
        wr(5'h14, 32'h8002);
        rd(5'h14, v); check("R9 ewctrl read", v, 32'h8002);
        rd(5'h0C, v); check("R8 ew flag", v, 32'h8);
        ticks(S);
        wr(5'h00, 32'hAAAA);
        count_until(1, 40, 0, n); check("R9 ew time", n, 20);
        count_until(0, 40, 0, n); check("R7 expiry after ew", n, 12);
        check("R9 ew sticky", {31'h0, ew_irq}, 32'h1);
        wr(5'h14, 32'hC002);
        check("R10 ew cleared", {31'h0, ew_irq}, 32'h0);
        rd(5'h14, v); check("R10 clear bit not stored", v, 32'h8002);
        ticks(S);

        // R9 disabled
        wr(5'h14, 32'h0002);
        ticks(S);
        wr(5'h14, 32'h4002);
        wr(5'h00, 32'hAAAA);
        count_until(1, 40, 0, n); check("R9 disabled", n, -1);

        // R9 compare equal to reload value: loads never set it
        wr(5'h14, 32'h8007);
        ticks(S);
        wr(5'h00, 32'hAAAA);
        count_until(1, 31, 0, n); check("R9 cmp at reload", n, -1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule